// File: doc/BRIEF.md
# Windowed Register File with Spill and Fill

The block is a processor register file in which a procedure call or return rotates a current window pointer instead of saving or restoring registers. The physical storage holds a set of global registers, visible at every pointer position, and a ring of windows. Each window owns its locals and its incoming parameters. Its outgoing temporaries are the physical registers that the next window in the ring uses as incoming parameters. A caller therefore writes arguments into its temporaries, and after the call the callee finds them among its parameters without any data having moved.

Two combinational read ports and one clocked write port take 5-bit architectural register numbers. Each number is translated to a physical register through the current window pointer. A saved window pointer marks the oldest window still held on chip. A call that would make the new window's temporaries overlap that oldest window raises an overflow trap. The block then spills the oldest window word by word over a valid/ready memory port before it completes the call. A return into a window that has already been spilled raises an underflow trap, and the block refills that window from memory before it completes the return. Instruction decode and the memory itself lie outside the block.

Top module: `regwin_top`

## Requirements
- R1: Architectural registers 0 to 7 map to the global registers. A value written to one of them reads back unchanged at every window pointer.
- R2: Architectural registers 8 to 15 are the outgoing temporaries, 16 to 23 the locals and 24 to 31 the incoming parameters of the current window. Temporary k of window w is the same physical register as parameter k of window w+1 (mod 8).
- R3: When no trap arises, an accepted call increments the current window pointer and an accepted return decrements it, both modulo 8. The change is visible after the clock edge.
- R4: After reset both window pointers are 0, busy and both trap outputs are low, no memory request is made, and every register reads 0.
- R5: A call accepted when (current pointer + 2) mod 8 equals the saved pointer raises the overflow trap for exactly one cycle and sets busy. The block then writes 16 words of the window at the saved pointer to memory address {window, k}, where k 0 to 7 are its locals and k 8 to 15 its parameters. It then advances both pointers by one.
- R6: A return accepted when the current pointer equals the saved pointer raises the underflow trap for exactly one cycle and sets busy. The block then reads the 16 words of window (current - 1) from {window, k}, with the same k layout as R5. It then sets both pointers to current - 1.
- R7: While busy is high, call and return inputs are ignored and the pointers hold. When call and return arrive together, the call is taken.
- R8: Reads are combinational. A read of the register being written in the same cycle returns the new data.
- R9: A memory word moves only in a cycle where request and ready are both high. While request is high and ready is low, the address and the direction stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Procedure call command |
| ret_i | input | 1 | Procedure return command |
| ra_addr_i | input | 5 | Read port A architectural register |
| ra_data_o | output | 32 | Read port A data |
| rb_addr_i | input | 5 | Read port B architectural register |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wa_addr_i | input | 5 | Write architectural register |
| wd_i | input | 32 | Write data |
| busy_o | output | 1 | Spill or fill in progress; commands stalled |
| ovf_o | output | 1 | Overflow trap pulse |
| unf_o | output | 1 | Underflow trap pulse |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Saved window pointer (oldest resident window) |
| mem_req_o | output | 1 | Memory transfer valid |
| mem_we_o | output | 1 | Memory write (spill) when high, read (fill) when low |
| mem_addr_o | output | 7 | Memory word address {window, k} |
| mem_wdata_o | output | 32 | Spill data |
| mem_rdata_i | input | 32 | Fill data, taken when ready is high |
| mem_ready_i | input | 1 | Memory accepts or delivers a word |

## Verification
The bench builds the block at its default sizes of eight windows of eight registers per region with 32-bit words. With these sizes a chain of six calls from reset brings the ring to the overflow point, and the trap condition there wraps around modulo 8. The bench's memory model holds ready low on a repeating pattern, so every 16-word spill and fill meets wait states. Commands issued in the middle of a transfer test the stall. A fill-data pattern that differs from the spilled contents shows that a refill really brings data back from memory.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } xfer_st_e;

  typedef enum logic [1:0] {
    RG_GLOB = 2'd0,
    RG_OUT  = 2'd1,
    RG_LOC  = 2'd2,
    RG_IN   = 2'd3
  } region_e;
endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  localparam int WW  = $clog2(NWIN),
  localparam int RW  = $clog2(NREG),
  localparam int AW  = RW + 2,
  localparam int NPHYS = NREG + NWIN * 2 * NREG,
  localparam int PW  = $clog2(NPHYS)
) (
  input  logic [AW-1:0] arch_i,
  input  logic [WW-1:0] cwp_i,
  output logic [PW-1:0] phys_o
);
  import regwin_pkg::*;

  region_e        region;
  logic [RW-1:0]  idx;
  logic [WW-1:0]  win;
  logic           is_in;

  assign region = region_e'(arch_i[AW-1:RW]);
  assign idx    = arch_i[RW-1:0];

  always_comb begin
    win   = cwp_i;
    is_in = 1'b0;
    case (region)
      RG_OUT: begin win = cwp_i + WW'(1); is_in = 1'b1; end // shared with next window
      RG_LOC: begin win = cwp_i;          is_in = 1'b0; end
      RG_IN:  begin win = cwp_i;          is_in = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    if (region == RG_GLOB) phys_o = PW'(idx);
    else                   phys_o = PW'(NREG) + PW'({win, is_in, idx});
  end
endmodule

// File: rtl/regwin_regs.sv
module regwin_regs #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int NRD  = 3,
  localparam int NPHYS = NREG + NWIN * 2 * NREG,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          uw_en_i,
  input  logic [PW-1:0] uw_idx_i,
  input  logic [DW-1:0] uw_data_i,
  input  logic          fw_en_i,
  input  logic [PW-1:0] fw_idx_i,
  input  logic [DW-1:0] fw_data_i,
  input  logic [PW-1:0] rd_idx_i  [NRD],
  output logic [DW-1:0] rd_data_o [NRD]
);
  logic [DW-1:0] rf_q [NPHYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NPHYS; i++) rf_q[i] <= '0;
    end else begin
      if (uw_en_i) rf_q[uw_idx_i] <= uw_data_i;
      // fill targets a window outside the current one, so indices never collide
      if (fw_en_i) rf_q[fw_idx_i] <= fw_data_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data_o[g] = (uw_en_i && uw_idx_i == rd_idx_i[g]) ? uw_data_i
                                                                : rf_q[rd_idx_i[g]];
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  localparam int WW  = $clog2(NWIN),
  localparam int CW  = $clog2(2 * NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          mem_ready_i,
  output logic [WW-1:0] cwp_o,
  output logic [WW-1:0] swp_o,
  output logic [WW-1:0] xfer_win_o,
  output logic [CW-1:0] xfer_cnt_o,
  output logic          busy_o,
  output logic          spill_o,
  output logic          hs_o,
  output logic          ovf_o,
  output logic          unf_o
);
  import regwin_pkg::*;

  xfer_st_e      st_q;
  logic [WW-1:0] cwp_q, swp_q, cwp_inc, cwp_dec, cwp_p2;
  logic [CW-1:0] cnt_q;
  logic          ovf_q, unf_q;
  logic          idle, call_go, ret_go, ovf_hit, unf_hit, last;

  assign idle    = (st_q == ST_IDLE);
  assign call_go = idle && call_i;
  assign ret_go  = idle && ret_i && !call_i;
  assign cwp_inc = cwp_q + WW'(1);
  assign cwp_dec = cwp_q - WW'(1);
  assign cwp_p2  = cwp_q + WW'(2);
  assign ovf_hit = call_go && (cwp_p2 == swp_q);
  assign unf_hit = ret_go && (cwp_q == swp_q);
  assign hs_o    = !idle && mem_ready_i;
  assign last    = hs_o && (cnt_q == CW'(2 * NREG - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cwp_q <= '0;
      swp_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_hit;
      unf_q <= unf_hit;
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (ovf_hit)      st_q  <= ST_SPILL;
          else if (call_go) cwp_q <= cwp_inc;
          else if (unf_hit) st_q  <= ST_FILL;
          else if (ret_go)  cwp_q <= cwp_dec;
        end
        ST_SPILL: begin
          if (hs_o) cnt_q <= cnt_q + CW'(1);
          if (last) begin
            st_q  <= ST_IDLE;
            cwp_q <= cwp_inc;
            swp_q <= swp_q + WW'(1);
          end
        end
        ST_FILL: begin
          if (hs_o) cnt_q <= cnt_q + CW'(1);
          if (last) begin
            st_q  <= ST_IDLE;
            cwp_q <= cwp_dec;
            swp_q <= cwp_dec;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cwp_o      = cwp_q;
  assign swp_o      = swp_q;
  assign busy_o     = !idle;
  assign spill_o    = (st_q == ST_SPILL);
  assign xfer_win_o = spill_o ? swp_q : cwp_dec;
  assign xfer_cnt_o = cnt_q;
  assign ovf_o      = ovf_q;
  assign unf_o      = unf_q;
endmodule

// File: rtl/regwin_top.sv
module regwin_top #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int WW  = $clog2(NWIN),
  localparam int RW  = $clog2(NREG),
  localparam int AW  = RW + 2,
  localparam int CW  = $clog2(2 * NREG),
  localparam int MAW = WW + CW,
  localparam int NPHYS = NREG + NWIN * 2 * NREG,
  localparam int PW  = $clog2(NPHYS),
  localparam int NRD = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic [AW-1:0]  ra_addr_i,
  output logic [DW-1:0]  ra_data_o,
  input  logic [AW-1:0]  rb_addr_i,
  output logic [DW-1:0]  rb_data_o,
  input  logic           we_i,
  input  logic [AW-1:0]  wa_addr_i,
  input  logic [DW-1:0]  wd_i,
  output logic           busy_o,
  output logic           ovf_o,
  output logic           unf_o,
  output logic [WW-1:0]  cwp_o,
  output logic [WW-1:0]  swp_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           mem_ready_i
);
  logic [WW-1:0] cwp, xfer_win;
  logic [CW-1:0] xfer_cnt;
  logic          spill, hs;
  logic [AW-1:0] arch_addr [3];
  logic [PW-1:0] phys_idx  [3];
  logic [PW-1:0] rd_idx    [NRD];
  logic [DW-1:0] rd_data   [NRD];
  logic [PW-1:0] xfer_idx;

  regwin_ctrl #(.NWIN(NWIN), .NREG(NREG)) ctrl_i (
    .clk_i, .rst_ni, .call_i, .ret_i, .mem_ready_i,
    .cwp_o(cwp), .swp_o, .xfer_win_o(xfer_win), .xfer_cnt_o(xfer_cnt),
    .busy_o, .spill_o(spill), .hs_o(hs), .ovf_o, .unf_o
  );

  assign arch_addr[0] = ra_addr_i;
  assign arch_addr[1] = rb_addr_i;
  assign arch_addr[2] = wa_addr_i;

  for (genvar g = 0; g < 3; g++) begin : g_map
    regwin_map #(.NWIN(NWIN), .NREG(NREG)) map_i (
      .arch_i(arch_addr[g]), .cwp_i(cwp), .phys_o(phys_idx[g])
    );
  end

  // transfer word k: locals for k < NREG, parameters above
  assign xfer_idx  = PW'(NREG) + PW'({xfer_win, xfer_cnt});
  assign rd_idx[0] = phys_idx[0];
  assign rd_idx[1] = phys_idx[1];
  assign rd_idx[2] = xfer_idx;

  regwin_regs #(.NWIN(NWIN), .NREG(NREG), .DW(DW), .NRD(NRD)) regs_i (
    .clk_i, .rst_ni,
    .uw_en_i(we_i), .uw_idx_i(phys_idx[2]), .uw_data_i(wd_i),
    .fw_en_i(hs && !spill), .fw_idx_i(xfer_idx), .fw_data_i(mem_rdata_i),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data)
  );

  assign ra_data_o   = rd_data[0];
  assign rb_data_o   = rd_data[1];
  assign cwp_o       = cwp;
  assign mem_req_o   = busy_o;
  assign mem_we_o    = spill;
  assign mem_addr_o  = {xfer_win, xfer_cnt};
  assign mem_wdata_o = rd_data[2];
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int WW  = $clog2(NWIN),
  localparam int MAW = WW + $clog2(2 * NREG)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           call_i,
  input logic           ret_i,
  input logic           busy_o,
  input logic           ovf_o,
  input logic           unf_o,
  input logic [WW-1:0]  cwp_o,
  input logic [WW-1:0]  swp_o,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [MAW-1:0] mem_addr_o,
  input logic           mem_ready_i
);
  logic [WW-1:0] cwp_plus2, cwp_next_exp;
  logic [WW-1:0] cwp_prev;

  assign cwp_plus2    = cwp_o + WW'(2);
  assign cwp_next_exp = cwp_o + WW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cwp_prev <= '0;
    else         cwp_prev <= cwp_next_exp;
  end

  assert_call_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && call_i && cwp_plus2 != swp_o) |=> (cwp_o == cwp_prev));

  assert_ovf_spill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (busy_o && mem_we_o));

  assert_ovf_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);

  assert_unf_fill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (busy_o && !mem_we_o));

  assert_trap_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $onehot({ovf_o, unf_o}));

  assert_busy_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_ready_i) |=> ($stable(cwp_o) && $stable(swp_o)));

  assert_req_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

bind regwin_top regwin_chk #(.NWIN(NWIN), .NREG(NREG), .DW(DW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
  .busy_o(busy_o), .ovf_o(ovf_o), .unf_o(unf_o), .cwp_o(cwp_o), .swp_o(swp_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_ready_i(mem_ready_i)
);

// File: tb/regwin_top_tb_top.sv
module regwin_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call = 1'b0, ret = 1'b0, we = 1'b0;
  logic [4:0]  ra = '0, rb = '0, wa = '0;
  logic [31:0] wd = '0;
  logic [31:0] ra_data, rb_data, mem_wdata, mem_rdata;
  logic        busy, ovf, unf, mem_req, mem_we;
  logic [2:0]  cwp, swp;
  logic [6:0]  mem_addr;
  logic        rdy = 1'b1;
  logic        fill_pat = 1'b0;
  logic [31:0] mem [128];
  int          spill_words = 0;
  int          cyc = 0;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  regwin_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .call_i(call), .ret_i(ret),
    .ra_addr_i(ra), .ra_data_o(ra_data), .rb_addr_i(rb), .rb_data_o(rb_data),
    .we_i(we), .wa_addr_i(wa), .wd_i(wd),
    .busy_o(busy), .ovf_o(ovf), .unf_o(unf), .cwp_o(cwp), .swp_o(swp),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(rdy)
  );

  // memory model with periodic wait states
  assign mem_rdata = fill_pat ? (32'h3000 + 32'(mem_addr[3:0])) : mem[mem_addr];
  always @(posedge clk) begin
    if (mem_req && rdy && mem_we) begin
      mem[mem_addr] <= mem_wdata;
      spill_words   <= spill_words + 1;
    end
  end
  always @(negedge clk) begin
    cyc <= cyc + 1;
    rdy <= (cyc % 3) != 2;
  end

  // {write reg, write data, read reg, expected}
  localparam logic [73:0] VEC [6] = '{
    {5'd1,  32'hA000_0001, 5'd1,  32'hA000_0001},
    {5'd9,  32'hB000_0009, 5'd1,  32'hA000_0001},
    {5'd17, 32'hC000_0011, 5'd9,  32'hB000_0009},
    {5'd25, 32'hD000_0019, 5'd17, 32'hC000_0011},
    {5'd7,  32'hE000_0007, 5'd25, 32'hD000_0019},
    {5'd31, 32'hF000_001F, 5'd7,  32'hE000_0007}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; wa = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rb = a; #1 d = rb_data;
  endtask

  task automatic cmd(input logic c, input logic r);
    @(negedge clk); call = c; ret = r;
    @(negedge clk); call = 1'b0; ret = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R4 reset state
    chk("R4 cwp", 32'(cwp), 0);
    chk("R4 swp", 32'(swp), 0);
    chk("R4 busy/trap/req", {28'd0, busy, ovf, unf, mem_req}, 0);
    rd(5'd20, v); chk("R4 reg clear", v, 0);
    @(negedge clk); rst_n = 1'b1;

    // table walk: R1 R2 R8
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      we = 1'b1; wa = VEC[i][73:69]; wd = VEC[i][68:37]; ra = VEC[i][36:32];
      #1 chk($sformatf("R8 R1 R2 vec%0d", i), ra_data, VEC[i][31:0]);
    end
    @(negedge clk); we = 1'b0;

    for (int j = 0; j < 8; j++) begin
      wr(5'(16 + j), 32'h1000 + 32'(j));
      wr(5'(24 + j), 32'h2000 + 32'(j));
    end
    wr(5'd8, 32'hCAFE_0008);

    // R3 R2 call: outs become ins
    cmd(1'b1, 1'b0);
    chk("R3 call cwp", 32'(cwp), 1);
    rd(5'd24, v); chk("R2 outs->ins", v, 32'hCAFE_0008);
    rd(5'd1, v);  chk("R1 global after call", v, 32'hA000_0001);
    rd(5'd16, v); chk("R2 fresh locals", v, 0);
    wr(5'd24, 32'hBEEF_0024);
    wr(5'd16, 32'h0000_0051);
    cmd(1'b0, 1'b1);
    chk("R3 ret cwp", 32'(cwp), 0);
    rd(5'd8, v);  chk("R2 ins->outs", v, 32'hBEEF_0024);
    rd(5'd16, v); chk("R2 locals kept", v, 32'h1000);

    // climb to window 6, no trap
    for (int k = 0; k < 6; k++) cmd(1'b1, 1'b0);
    chk("R3 cwp after climb", 32'(cwp), 6);
    chk("R5 no trap on climb", {31'd0, ovf}, 0);

    // R5 overflow (6+2 mod 8 == 0)
    cmd(1'b1, 1'b0);
    chk("R5 ovf pulse", {30'd0, ovf, busy}, 3);
    @(negedge clk);
    chk("R5 ovf one cycle", {31'd0, ovf}, 0);
    ret = 1'b1; call = 1'b1;
    repeat (2) @(negedge clk);
    ret = 1'b0; call = 1'b0;
    chk("R7 hold while busy", 32'(cwp), 6);
    wait_idle();
    chk("R5 R7 cwp after spill", 32'(cwp), 7);
    chk("R5 swp after spill", 32'(swp), 1);
    chk("R9 spill words", 32'(spill_words), 16);
    for (int j = 0; j < 8; j++) begin
      chk("R5 spill local", mem[j], 32'h1000 + 32'(j));
      chk("R5 spill in", mem[8 + j], 32'h2000 + 32'(j));
    end

    // back down to window 1
    for (int k = 0; k < 6; k++) cmd(1'b0, 1'b1);
    chk("R3 cwp after descent", 32'(cwp), 1);
    chk("R6 no unf on descent", {31'd0, unf}, 0);

    // R6 underflow with distinct fill pattern
    fill_pat = 1'b1;
    cmd(1'b0, 1'b1);
    chk("R6 unf pulse", {30'd0, unf, busy}, 3);
    chk("R6 fill direction", {31'd0, mem_we}, 0);
    wait_idle();
    fill_pat = 1'b0;
    chk("R6 cwp after fill", 32'(cwp), 0);
    chk("R6 swp after fill", 32'(swp), 0);
    rd(5'd16, v); chk("R6 fill local", v, 32'h3000);
    rd(5'd31, v); chk("R6 fill in", v, 32'h300F);

    // R7 call wins
    cmd(1'b1, 1'b1);
    chk("R7 call priority", 32'(cwp), 1);
    rd(5'd2, v); chk("R1 global r2 untouched", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule